// File: doc/BRIEF.md
# SDI Serial Encoder Core

This block turns 10-bit parallel video words into a single serial bit stream. It runs entirely on the bit-rate clock, which is ten times the word rate. A load strobe, pulsed once every ten clocks, hands each new word to a 10:1 shift register. The shift register emits the word least significant bit first.

In normal mode each serial bit passes through a self-synchronizing scrambler with generator x^9 + x^4 + 1. The result then goes through an x + 1 NRZI encoder, so every scrambled 1 becomes a level change on the line. A bypass select routes the raw shifter output to the line instead, for transparent transport. A lock flag from the clock multiplier gates the whole path. While lock is low the line is held at 0 and the coding state is frozen. The lock flag is also passed through to a status output.

Top module: `sdi_serial_encoder`

## Requirements
- R1: A word captured on the clock edge where load_i is high is emitted LSB first. Its bit k drives sdo_o after the (k+1)-th following rising edge, so its bit 0 appears one edge after the capture.
- R2: With load_i pulsed on every tenth edge, consecutive words form a continuous stream with no bit dropped or repeated.
- R3: When no load occurs, the shift register fills with zeros from its top. Ten edges after the last bit of a word, the raw stream is all 0.
- R4: With bypass_i high and lock_i high, sdo_o after an edge equals the raw serial bit presented before that edge.
- R5: With bypass_i low, the scrambled bit is s = d XOR s(n-4) XOR s(n-9). Here d is the raw bit and s(n-j) is the scrambled bit from j locked edges earlier. The scramble register starts at zero after reset.
- R6: With bypass_i low and lock_i high, the NRZI level toggles on each scrambled 1 and holds on each 0, and sdo_o shows the new level. Starting from reset, the single word 0x001 produces sdo_o bits 1,1,1,1,0,0,0,0,1,0.
- R7: An edge with lock_i low drives sdo_o to 0.
- R8: Edges with lock_i low leave the scrambler and NRZI state unchanged. The coded stream resumes exactly where it stopped.
- R9: lock_o follows lock_i combinationally.
- R10: After reset all state is zero and sdo_o is 0.
- R11: The scrambler and NRZI state keep advancing on locked edges while bypass_i is high, so that switching modes does not stall them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_i | input | 10 | Parallel word to serialize |
| load_i | input | 1 | Word load strobe, one clock in ten |
| bypass_i | input | 1 | 1: raw serial output, 0: scrambled NRZI |
| lock_i | input | 1 | Clock multiplier locked |
| sdo_o | output | 1 | Serial data out |
| lock_o | output | 1 | Lock status pass-through |

## Verification
Every cycle, the assertions check the following. The shifter captures the word on a strobe and back-fills zeros without one. Bypass output equals the raw bit. The line is 0 after any unlocked edge. Scrambler and NRZI state stay still while unlocked, and NRZI state holds on a scrambled 0. Only the bench scenarios can show that the scrambled sequence is correct: a known reference word, a model-based walk over mixed bypass and lock patterns, and a descrambler in the bench that recovers the original words from the line. The same scenarios also show the correct resumption after an unlocked gap.

// File: rtl/sdi_ser_pkg.sv
package sdi_ser_pkg;
  localparam int unsigned WORD_W = 10;
  localparam int unsigned TAP_LO = 4;
  localparam int unsigned TAP_HI = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sdi_ser_shift.sv
module sdi_ser_shift #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q, sh_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W-1) begin : g_top
      assign sh_d[i] = load_i ? word_i[i] : 1'b0;
    end else begin : g_mid
      assign sh_d[i] = load_i ? word_i[i] : sh_q[i+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign bit_o = sh_q[0];

  a_r2_load_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sh_q == $past(word_i));
  a_r3_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> !sh_q[W-1]);
endmodule

// File: rtl/sdi_ser_scram.sv
module sdi_ser_scram #(
  parameter int unsigned TAP_LO = 4,
  parameter int unsigned TAP_HI = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic s_o
);
  logic [TAP_HI-1:0] st_q;

  // history: st_q[j-1] holds the scrambled bit from j enabled edges ago
  assign s_o = d_i ^ st_q[TAP_LO-1] ^ st_q[TAP_HI-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   st_q <= '0;
    else if (en_i) st_q <= {st_q[TAP_HI-2:0], s_o};
  end

  a_r8_scram_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(st_q));
  a_r5_history_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> st_q[TAP_HI-1:1] == $past(st_q[TAP_HI-2:0]));
endmodule

// File: rtl/sdi_ser_nrzi.sv
module sdi_ser_nrzi (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic s_i,
  output logic lvl_o
);
  logic lvl_q;

  assign lvl_o = lvl_q ^ s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lvl_q <= 1'b0;
    else if (en_i) lvl_q <= lvl_o;
  end

  a_r6_hold_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !s_i) |=> $stable(lvl_q));
  a_r8_nrzi_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(lvl_q));
endmodule

// File: rtl/sdi_serial_encoder.sv
module sdi_serial_encoder
  import sdi_ser_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned TL = TAP_LO,
  parameter int unsigned TH = TAP_HI
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  input  logic         load_i,
  input  logic         bypass_i,
  input  logic         lock_i,
  output logic         sdo_o,
  output logic         lock_o
);
  logic raw_bit, scr_bit, nrzi_lvl, sdo_q;

  sdi_ser_shift #(.W(W)) u_shift (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .word_i(word_i), .bit_o(raw_bit)
  );

  sdi_ser_scram #(.TAP_LO(TL), .TAP_HI(TH)) u_scram (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(lock_i),
    .d_i(raw_bit), .s_o(scr_bit)
  );

  sdi_ser_nrzi u_nrzi (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(lock_i),
    .s_i(scr_bit), .lvl_o(nrzi_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sdo_q <= 1'b0;
    else if (!lock_i)  sdo_q <= 1'b0;
    else if (bypass_i) sdo_q <= raw_bit;
    else               sdo_q <= nrzi_lvl;
  end

  assign sdo_o  = sdo_q;
  assign lock_o = lock_i;

  a_r7_off_when_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> !sdo_o);
  a_r4_bypass_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && bypass_i) |=> sdo_o == $past(raw_bit));
endmodule

// File: tb/sim_sdi_serial_encoder.sv
module sim_sdi_serial_encoder;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 8;
  // {bypass, word}
  localparam logic [10:0] VECS [NVEC] = '{
    {1'b1, 10'h3A5}, {1'b0, 10'h3FF}, {1'b0, 10'h000}, {1'b1, 10'h001},
    {1'b0, 10'h200}, {1'b0, 10'h155}, {1'b1, 10'h2AA}, {1'b0, 10'h0F3}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [9:0] word_i = '0;
  logic load_i = 1'b0, bypass_i = 1'b0, lock_i = 1'b0;
  logic sdo_o, lock_o;

  int n_chk = 0, n_fail = 0;
  logic [9:0] m_sh = '0;
  logic [8:0] m_scr = '0;
  logic m_n = 1'b0;
  logic [39:0] hist = '0, dhist = '0;
  logic rx_prev = 1'b0;
  logic [8:0] rx_sh = '0;

  sdi_serial_encoder u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_i(word_i), .load_i(load_i),
    .bypass_i(bypass_i), .lock_i(lock_i), .sdo_o(sdo_o), .lock_o(lock_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [39:0] got, input logic [39:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one clock: drive at negedge, predict, sample at next negedge
  task automatic step(input logic ld, input logic [9:0] w, input logic byp,
                      input logic lk, output logic got, output logic exp);
    logic cur, s, rn;
    load_i = ld; word_i = w; bypass_i = byp; lock_i = lk;
    cur = m_sh[0];
    s   = cur ^ m_scr[3] ^ m_scr[8];
    exp = !lk ? 1'b0 : (byp ? cur : (m_n ^ s));
    if (lk) begin
      m_scr = {m_scr[7:0], s};
      m_n   = m_n ^ s;
    end
    m_sh = ld ? w : {1'b0, m_sh[9:1]};
    @(posedge clk_i);
    @(negedge clk_i);
    got  = sdo_o;
    hist = {got, hist[39:1]};
    if (lk && !byp) begin
      rn      = got ^ rx_prev;
      rx_prev = got;
      dhist   = {rn ^ rx_sh[3] ^ rx_sh[8], dhist[39:1]};
      rx_sh   = {rx_sh[7:0], rn};
    end
  endtask

  task automatic send(input logic [9:0] w, input logic byp, input logic lk,
                      output logic [9:0] got, output logic [9:0] exp);
    for (int k = 0; k < 10; k++) begin
      logic g, e;
      step(k == 0, w, byp, lk, g, e);
      got[k] = g; exp[k] = e;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [9:0] g, e;
    logic g1, e1;
    repeat (3) @(negedge clk_i);
    // R10: reset state
    check("R10 sdo after reset", {39'b0, sdo_o}, 40'h0);
    rst_ni = 1'b1;
    lock_i = 1'b1;
    #1;
    check("R9 lock_o high", {39'b0, lock_o}, 40'h1);

    // R6/R5/R1: known reference word from reset state
    send(10'h001, 1'b0, 1'b1, g, e);
    step(1'b0, 10'h000, 1'b0, 1'b1, g1, e1);
    check("R6 R5 ref word 0x001", {30'b0, hist[39:30]}, {30'b0, 10'b0100001111});

    // table walk: R1 R2 R4 R11
    for (int i = 0; i < NVEC; i++) begin
      send(VECS[i][9:0], VECS[i][10], 1'b1, g, e);
      check(VECS[i][10] ? "R4 R1 R11 bypass word" : "R2 R5 R6 scrambled word",
            {30'b0, g}, {30'b0, e});
    end

    // R4/R1 direct: bypass word appears LSB first, one edge late
    send(10'h2C6, 1'b1, 1'b1, g, e);
    step(1'b1, 10'h000, 1'b1, 1'b1, g1, e1);
    check("R1 R4 raw lsb first", {30'b0, hist[39:30]}, {30'b0, 10'h2C6});

    // R3: no strobe -> zeros after the word
    send(10'h3FF, 1'b1, 1'b1, g, e);
    for (int k = 0; k < 10; k++) step(1'b0, 10'h3FF, 1'b1, 1'b1, g1, e1);
    check("R3 zero fill", {30'b0, hist[39:30]}, {30'b0, 10'h001});

    // R7/R9: unlocked -> line 0, lock_o low
    send(10'h3FF, 1'b0, 1'b0, g, e);
    check("R7 unlocked output", {30'b0, g}, 40'h0);
    check("R9 lock_o low", {39'b0, lock_o}, 40'h0);

    // R8: resume after gap matches frozen-state prediction
    send(10'h1B7, 1'b0, 1'b1, g, e);
    check("R8 resume after gap", {30'b0, g}, {30'b0, e});
    send(10'h05A, 1'b0, 1'b1, g, e);
    check("R8 resume second word", {30'b0, g}, {30'b0, e});

    // R5/R2: self-synchronizing descramble of the line recovers words
    send(10'h123, 1'b0, 1'b1, g, e);
    send(10'h2DE, 1'b0, 1'b1, g, e);
    send(10'h31C, 1'b0, 1'b1, g, e);
    step(1'b1, 10'h000, 1'b0, 1'b1, g1, e1);
    check("R5 R2 descrambled word", {30'b0, dhist[39:30]}, {30'b0, 10'h31C});

    // R11: bypass segment then scrambled, model keeps state continuity
    send(10'h0C3, 1'b1, 1'b1, g, e);
    send(10'h3C0, 1'b0, 1'b1, g, e);
    check("R11 scrambled after bypass", {30'b0, g}, {30'b0, e});

    // R10: asynchronous reset clears the line
    rst_ni = 1'b0;
    #1;
    check("R10 async reset", {39'b0, sdo_o}, 40'h0);
    m_sh = '0; m_scr = '0; m_n = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    send(10'h001, 1'b0, 1'b1, g, e);
    step(1'b0, 10'h000, 1'b0, 1'b1, g1, e1);
    check("R6 R10 ref after reset", {30'b0, hist[39:30]}, {30'b0, 10'b0100001111});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule